// File: doc/BRIEF.md
# Half-Bridge Protection Sequencer

This block supervises a resonant half-bridge converter. It does not touch any analog signal. It takes digitized comparator flags (supply, current sense, shutdown, line and standby), and it models the overcurrent delay capacitor as a saturating counter. From these it decides whether the bridge may switch. It also drives three more outputs: a soft-start discharge request, a forced-maximum-frequency request and an active-low request to stop the power-factor pre-regulator.

Overcurrent handling has two levels. A first trip pushes the frequency up and starts charging the delay level. If the level reaches the push threshold, maximum frequency is held and charging becomes continuous. If the level then crosses the shutdown threshold, switching stops and the level bleeds down until it passes the restart threshold, which gives hiccup operation. A hard current trip or the shutdown input latches the block off, and only a supply drop clears that latch. Line brownout and line clamp are not latched. A low standby level gives burst idle.

The state machine has seven states:
- `ST_UVLO`: supply not good.
- `ST_RUN`: switching.
- `ST_IDLE`: burst idle.
- `ST_OCP_OFF`: timed overcurrent shutdown.
- `ST_BROWN`: line low.
- `ST_CLAMP`: line overvoltage.
- `ST_LATCH`: latched off.

Each cycle the next state is chosen by priority:
1. Any state goes to `ST_UVLO` when the supply is not good.
2. Otherwise it goes to `ST_LATCH` on a latch cause, or stays there.
3. Otherwise it goes to `ST_OCP_OFF` when the level is above the shutdown threshold. From `ST_OCP_OFF` it stays there until the level is below the restart threshold.
4. Otherwise it goes to `ST_CLAMP` on line overvoltage.
5. Otherwise it goes to `ST_BROWN` on line low.
6. Otherwise it goes to `ST_IDLE` while the standby hysteresis flag is set.
7. Otherwise it goes to `ST_RUN`.

Top module: `rhb_prot_seq`

## Requirements
- R1: A registered supply-good flag sets when `vcc_on_i` is 1 and clears only when `vcc_hold_i` is 0. While the flag is clear, the state is `ST_UVLO`, with `run_en_o`=0, `ss_reset_o`=1, `force_fmax_o`=0 and `pfc_stop_n_o`=1.
- R2: An overcurrent flag sets on `cs_trip_i` and stays set while `cs_hold_i` is 1. In `ST_RUN` with the flag set, `ss_reset_o`=1 and the delay level rises by CHARGE_STEP each cycle.
- R3: With the charge source off, the delay level falls by BLEED_STEP each cycle. It saturates at 0 and at 2^LVL_W-1, and it is cleared while the supply is not good.
- R4: Once the level reaches FMAX_LVL, `force_fmax_o`=1, `ss_reset_o`=1 and `pfc_stop_n_o`=0. Charging then continues every cycle, whatever the current flags do, until the restart.
- R5: A level above SHUT_LVL enters `ST_OCP_OFF`. There `run_en_o`=0 and the charge source is off.
- R6: `ST_OCP_OFF` is left when the level is below RESTART_LVL. Forced maximum frequency then ends and `pfc_stop_n_o` returns to 1.
- R7: `cs_latch_i` or `shdn_i` enters `ST_LATCH`, with `run_en_o`=0 and `pfc_stop_n_o`=0. The state is held until the supply-good flag clears.
- R8: `line_low_i` gives `ST_BROWN` and `line_ovp_i` gives `ST_CLAMP`. Both are non-latched, with `run_en_o`=0 and `ss_reset_o`=1. `pfc_stop_n_o` is 0 only in `ST_CLAMP`.
- R9: `stby_low_i` sets an idle flag, and only `stby_wake_i` clears it. In `ST_IDLE`, `run_en_o`=0 and `pfc_stop_n_o`=0, and `ss_reset_o`=0 (the soft-start charge is kept) unless maximum frequency is forced.
- R10: Priority is UVLO, then latch, then timed overcurrent, then line clamp or brownout, then idle.
- R11: The flags are registered. The state takes the flags and the level one clock later, and the outputs are decoded from registers only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vcc_on_i | input | 1 | Supply above turn-on level |
| vcc_hold_i | input | 1 | Supply above turn-off level |
| cs_trip_i | input | 1 | Current sense above first trip level |
| cs_hold_i | input | 1 | Current sense above release level |
| cs_latch_i | input | 1 | Current sense above hard latch level |
| shdn_i | input | 1 | Latched shutdown request |
| line_low_i | input | 1 | Line below brownout level |
| line_ovp_i | input | 1 | Line clamped high |
| stby_low_i | input | 1 | Standby below idle level |
| stby_wake_i | input | 1 | Standby above wake level |
| run_en_o | output | 1 | Bridge switching enable |
| ss_reset_o | output | 1 | Discharge soft-start |
| force_fmax_o | output | 1 | Force maximum frequency |
| pfc_stop_n_o | output | 1 | Stop pre-regulator, active low |

## Verification
A flag change at the inputs reaches its hysteresis register at the next edge, and it reaches the state and the outputs one edge after that. The latch, line and level inputs act through the next-state logic, so they show at the outputs one edge after they are applied. Delay-level thresholds act one edge after the level crosses them. The bench reference model holds these registers as plain variables and advances them at every rising edge. It compares all four outputs at every falling edge, and it drives new stimulus just after the falling edge, so each comparison falls exactly in the cycle where the result is due.

// File: rtl/rhb_prot_pkg.sv
package rhb_prot_pkg;
    typedef enum logic [2:0] {
        ST_UVLO    = 3'd0,
        ST_RUN     = 3'd1,
        ST_IDLE    = 3'd2,
        ST_OCP_OFF = 3'd3,
        ST_BROWN   = 3'd4,
        ST_CLAMP   = 3'd5,
        ST_LATCH   = 3'd6
    } prot_state_e;
endpackage

// File: rtl/rhb_hyst_flag.sv
// Set/hold flag: sets on set_i, remains while keep_i, otherwise clears.
module rhb_hyst_flag #(
    parameter bit CLR_ON_LOW_KEEP = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic keep_i,
    output logic flag_o
);
    logic flag_q;

    generate
        if (CLR_ON_LOW_KEEP) begin : g_keep_low_clears
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       flag_q <= 1'b0;
                else if (set_i)   flag_q <= 1'b1;
                else if (!keep_i) flag_q <= 1'b0;
            end
        end else begin : g_keep_high_clears
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      flag_q <= 1'b0;
                else if (set_i)  flag_q <= 1'b1;
                else if (keep_i) flag_q <= 1'b0;
            end
        end
    endgenerate

    assign flag_o = flag_q;
endmodule

// File: rtl/rhb_delay_level.sv
// Saturating model of the overcurrent delay capacitor.
module rhb_delay_level #(
    parameter int LVL_W       = 10,
    parameter int CHARGE_STEP = 4,
    parameter int BLEED_STEP  = 1,
    parameter int FMAX_LVL    = 400,
    parameter int SHUT_LVL    = 700,
    parameter int RESTART_LVL = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             charge_i,
    output logic [LVL_W-1:0] level_o,
    output logic             at_fmax_o,
    output logic             above_shut_o,
    output logic             below_restart_o
);
    localparam logic [LVL_W:0]   CH_EXT  = (LVL_W+1)'(CHARGE_STEP);
    localparam logic [LVL_W-1:0] BL_VAL  = LVL_W'(BLEED_STEP);
    localparam logic [LVL_W:0]   LVL_MAX = (LVL_W+1)'((1 << LVL_W) - 1);

    logic [LVL_W-1:0] level_q;
    logic [LVL_W-1:0] level_d;
    logic [LVL_W:0]   up_sum;

    assign up_sum = {1'b0, level_q} + CH_EXT;

    always_comb begin
        if (clear_i)
            level_d = '0;
        else if (charge_i)
            level_d = (up_sum > LVL_MAX) ? LVL_MAX[LVL_W-1:0] : up_sum[LVL_W-1:0];
        else if (level_q < BL_VAL)
            level_d = '0;
        else
            level_d = level_q - BL_VAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_d;
    end

    assign level_o         = level_q;
    assign at_fmax_o       = int'(level_q) >= FMAX_LVL;
    assign above_shut_o    = int'(level_q) >  SHUT_LVL;
    assign below_restart_o = int'(level_q) <  RESTART_LVL;
endmodule

// File: rtl/rhb_prot_fsm.sv
module rhb_prot_fsm
    import rhb_prot_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        supply_ok_i,
    input  logic        ocp_i,
    input  logic        idle_i,
    input  logic        latch_req_i,
    input  logic        line_low_i,
    input  logic        line_ovp_i,
    input  logic        at_fmax_i,
    input  logic        above_shut_i,
    input  logic        below_restart_i,
    output prot_state_e state_o,
    output logic        charge_o,
    output logic        run_en_o,
    output logic        ss_reset_o,
    output logic        force_fmax_o,
    output logic        pfc_stop_n_o
);
    prot_state_e state_q, state_d;
    logic        fmax_q, fmax_d;

    // Next state, fixed priority.
    always_comb begin
        if (!supply_ok_i)
            state_d = ST_UVLO;
        else if (state_q == ST_LATCH || latch_req_i)
            state_d = ST_LATCH;
        else if ((state_q == ST_OCP_OFF && !below_restart_i) || above_shut_i)
            state_d = ST_OCP_OFF;
        else if (line_ovp_i)
            state_d = ST_CLAMP;
        else if (line_low_i)
            state_d = ST_BROWN;
        else if (idle_i)
            state_d = ST_IDLE;
        else
            state_d = ST_RUN;
    end

    always_comb begin
        if (!supply_ok_i)         fmax_d = 1'b0;
        else if (at_fmax_i)       fmax_d = 1'b1;
        else if (below_restart_i) fmax_d = 1'b0;
        else                      fmax_d = fmax_q;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_UVLO;
            fmax_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fmax_q  <= fmax_d;
        end
    end

    // Output decode from registers only.
    always_comb begin
        run_en_o     = 1'b0;
        ss_reset_o   = fmax_q;
        force_fmax_o = fmax_q;
        pfc_stop_n_o = !fmax_q;
        charge_o     = 1'b0;
        unique case (state_q)
            ST_UVLO: begin
                ss_reset_o   = 1'b1;
                force_fmax_o = 1'b0;
                pfc_stop_n_o = 1'b1;
            end
            ST_RUN: begin
                run_en_o   = 1'b1;
                ss_reset_o = fmax_q || ocp_i;
                charge_o   = fmax_q || ocp_i;
            end
            ST_IDLE: begin
                pfc_stop_n_o = 1'b0;
                charge_o     = fmax_q;
            end
            ST_OCP_OFF: begin
                ss_reset_o = 1'b1;
            end
            ST_BROWN: begin
                ss_reset_o = 1'b1;
                charge_o   = fmax_q;
            end
            ST_CLAMP: begin
                ss_reset_o   = 1'b1;
                pfc_stop_n_o = 1'b0;
                charge_o     = fmax_q;
            end
            ST_LATCH: begin
                ss_reset_o   = 1'b1;
                pfc_stop_n_o = 1'b0;
            end
            default: begin
                ss_reset_o = 1'b1;
            end
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/rhb_prot_seq.sv
module rhb_prot_seq
    import rhb_prot_pkg::*;
#(
    parameter int LVL_W       = 10,
    parameter int CHARGE_STEP = 4,
    parameter int BLEED_STEP  = 1,
    parameter int FMAX_LVL    = 400,
    parameter int SHUT_LVL    = 700,
    parameter int RESTART_LVL = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_on_i,
    input  logic vcc_hold_i,
    input  logic cs_trip_i,
    input  logic cs_hold_i,
    input  logic cs_latch_i,
    input  logic shdn_i,
    input  logic line_low_i,
    input  logic line_ovp_i,
    input  logic stby_low_i,
    input  logic stby_wake_i,
    output logic run_en_o,
    output logic ss_reset_o,
    output logic force_fmax_o,
    output logic pfc_stop_n_o
);
    logic             supply_ok, ocp_act, idle_act;
    logic             charge_on;
    logic [LVL_W-1:0] level;
    logic             at_fmax, above_shut, below_restart;
    prot_state_e      state_q;

    rhb_hyst_flag #(.CLR_ON_LOW_KEEP(1'b1)) u_supply (
        .clk(clk), .rst_n(rst_n), .set_i(vcc_on_i), .keep_i(vcc_hold_i), .flag_o(supply_ok));

    rhb_hyst_flag #(.CLR_ON_LOW_KEEP(1'b1)) u_ocp (
        .clk(clk), .rst_n(rst_n), .set_i(cs_trip_i), .keep_i(cs_hold_i), .flag_o(ocp_act));

    rhb_hyst_flag #(.CLR_ON_LOW_KEEP(1'b0)) u_idle (
        .clk(clk), .rst_n(rst_n), .set_i(stby_low_i), .keep_i(stby_wake_i), .flag_o(idle_act));

    rhb_delay_level #(
        .LVL_W(LVL_W), .CHARGE_STEP(CHARGE_STEP), .BLEED_STEP(BLEED_STEP),
        .FMAX_LVL(FMAX_LVL), .SHUT_LVL(SHUT_LVL), .RESTART_LVL(RESTART_LVL)
    ) u_level (
        .clk(clk), .rst_n(rst_n), .clear_i(!supply_ok), .charge_i(charge_on),
        .level_o(level), .at_fmax_o(at_fmax), .above_shut_o(above_shut),
        .below_restart_o(below_restart));

    rhb_prot_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .supply_ok_i(supply_ok), .ocp_i(ocp_act), .idle_i(idle_act),
        .latch_req_i(cs_latch_i || shdn_i),
        .line_low_i(line_low_i), .line_ovp_i(line_ovp_i),
        .at_fmax_i(at_fmax), .above_shut_i(above_shut), .below_restart_i(below_restart),
        .state_o(state_q), .charge_o(charge_on),
        .run_en_o(run_en_o), .ss_reset_o(ss_reset_o),
        .force_fmax_o(force_fmax_o), .pfc_stop_n_o(pfc_stop_n_o));
endmodule

// File: rtl/rhb_prot_seq_chk.sv
module rhb_prot_seq_chk
    import rhb_prot_pkg::*;
#(
    parameter int LVL_W       = 10,
    parameter int CHARGE_STEP = 4,
    parameter int BLEED_STEP  = 1
) (
    input logic             clk,
    input logic             rst_n,
    input prot_state_e      state,
    input logic             supply_ok,
    input logic             charge_on,
    input logic [LVL_W-1:0] level,
    input logic             run_en,
    input logic             pfc_stop_n
);
    p_uvlo_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_UVLO |-> (!run_en && pfc_stop_n));

    p_rise_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= int'($past(level)) + CHARGE_STEP);

    p_bleed_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(charge_on) && int'($past(level)) >= BLEED_STEP)
        |-> (int'(level) == int'($past(level)) - BLEED_STEP || level == '0));

    p_off_no_charge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_OCP_OFF |-> !charge_on);

    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH && supply_ok) |=> state == ST_LATCH);

    p_idle_pfc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> (!pfc_stop_n && !run_en));
endmodule

bind rhb_prot_seq rhb_prot_seq_chk #(
    .LVL_W(LVL_W), .CHARGE_STEP(CHARGE_STEP), .BLEED_STEP(BLEED_STEP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .supply_ok(supply_ok),
    .charge_on(charge_on), .level(level), .run_en(run_en_o), .pfc_stop_n(pfc_stop_n_o));

// File: tb/tb_rhb_prot_seq.sv
module tb_rhb_prot_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CH = 4, BL = 1, FM = 400, SH = 700, RS = 60, LMAX = 1023;
    localparam int S_UVLO = 0, S_RUN = 1, S_IDLE = 2, S_OFF = 3, S_BROWN = 4, S_CLAMP = 5, S_LATCH = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic vcc_on = 0, vcc_hold = 0, cs_trip = 0, cs_hold = 0, cs_latch = 0, shdn = 0;
    logic line_low = 0, line_ovp = 0, stby_low = 0, stby_wake = 0;
    logic run_en, ss_reset, force_fmax, pfc_stop_n;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rhb_prot_seq dut (
        .clk(clk), .rst_n(rst_n), .vcc_on_i(vcc_on), .vcc_hold_i(vcc_hold),
        .cs_trip_i(cs_trip), .cs_hold_i(cs_hold), .cs_latch_i(cs_latch), .shdn_i(shdn),
        .line_low_i(line_low), .line_ovp_i(line_ovp), .stby_low_i(stby_low),
        .stby_wake_i(stby_wake), .run_en_o(run_en), .ss_reset_o(ss_reset),
        .force_fmax_o(force_fmax), .pfc_stop_n_o(pfc_stop_n));

    // Behavioural reference model
    bit m_sg, m_ocp, m_idle, m_fm;
    int m_lvl, m_st;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sg = 0; m_ocp = 0; m_idle = 0; m_fm = 0; m_lvl = 0; m_st = S_UVLO;
        end else begin
            bit chg, n_fm; int n_lvl, n_st;
            chg = (m_st == S_RUN && (m_fm || m_ocp)) ||
                  ((m_st == S_IDLE || m_st == S_BROWN || m_st == S_CLAMP) && m_fm);
            if (!m_sg) n_st = S_UVLO;
            else if (m_st == S_LATCH || cs_latch || shdn) n_st = S_LATCH;
            else if ((m_st == S_OFF && m_lvl >= RS) || m_lvl > SH) n_st = S_OFF;
            else if (line_ovp) n_st = S_CLAMP;
            else if (line_low) n_st = S_BROWN;
            else if (m_idle) n_st = S_IDLE;
            else n_st = S_RUN;
            if (!m_sg) n_fm = 0;
            else if (m_lvl >= FM) n_fm = 1;
            else if (m_lvl < RS) n_fm = 0;
            else n_fm = m_fm;
            if (!m_sg) n_lvl = 0;
            else if (chg) n_lvl = (m_lvl + CH > LMAX) ? LMAX : m_lvl + CH;
            else n_lvl = (m_lvl < BL) ? 0 : m_lvl - BL;
            m_st = n_st; m_fm = n_fm; m_lvl = n_lvl;
            if (vcc_on) m_sg = 1; else if (!vcc_hold) m_sg = 0;
            if (cs_trip) m_ocp = 1; else if (!cs_hold) m_ocp = 0;
            if (stby_low) m_idle = 1; else if (stby_wake) m_idle = 0;
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) if (rst_n) begin
        bit e_run, e_ss, e_pfc;
        e_run = (m_st == S_RUN);
        e_ss  = (m_st != S_RUN && m_st != S_IDLE) || m_fm || (m_st == S_RUN && m_ocp);
        e_pfc = (m_st == S_UVLO) ||
                !(m_st == S_LATCH || m_st == S_IDLE || m_st == S_CLAMP || m_fm);
        chk(run_en, e_run, "R11 run_en");
        chk(ss_reset, e_ss, "R2 ss_reset");
        chk(force_fmax, (m_st != S_UVLO) && m_fm, "R3 force_fmax");
        chk(pfc_stop_n, e_pfc, "R4 pfc_stop_n");
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3); rst_n = 1; cyc(1);
        // R1 reset / UVLO state
        chk(run_en, 1'b0, "R1 reset run"); chk(ss_reset, 1'b1, "R1 reset ss");
        chk(pfc_stop_n, 1'b1, "R1 reset pfc");
        vcc_on = 1; vcc_hold = 1; cyc(3);
        chk(run_en, 1'b1, "R11 start run");
        vcc_on = 0; cyc(5);
        chk(run_en, 1'b1, "R1 hysteresis keeps running");
        // R9 burst idle
        stby_low = 1; cyc(1); stby_low = 0; cyc(4);
        chk(run_en, 1'b0, "R9 idle run"); chk(pfc_stop_n, 1'b0, "R9 idle pfc");
        chk(ss_reset, 1'b0, "R9 idle keeps soft-start");
        stby_wake = 1; cyc(3); stby_wake = 0;
        chk(run_en, 1'b1, "R9 wake");
        // R2..R6 overcurrent hiccup
        cs_trip = 1; cs_hold = 1; cyc(1); cs_trip = 0; cyc(2);
        chk(ss_reset, 1'b1, "R2 trip ss");
        for (int i = 0; i < 2000 && !force_fmax; i++) cyc(1);
        chk(force_fmax, 1'b1, "R4 fmax reached"); chk(pfc_stop_n, 1'b0, "R4 pfc low");
        cs_hold = 0;
        for (int i = 0; i < 2000 && run_en; i++) cyc(1);
        chk(run_en, 1'b0, "R5 overcurrent off");
        cyc(20);
        chk(run_en, 1'b0, "R5 stays off while high");
        for (int i = 0; i < 4000 && !run_en; i++) cyc(1);
        chk(run_en, 1'b1, "R6 restart"); chk(force_fmax, 1'b0, "R6 fmax released");
        chk(pfc_stop_n, 1'b1, "R6 pfc released");
        cyc(200); // level bleeds to bottom (R3)
        // R8 line
        line_low = 1; cyc(2);
        chk(run_en, 1'b0, "R8 brown run"); chk(ss_reset, 1'b1, "R8 brown ss");
        chk(pfc_stop_n, 1'b1, "R8 brown pfc open");
        line_low = 0; cyc(2); chk(run_en, 1'b1, "R8 brown resumes");
        line_ovp = 1; cyc(2); chk(pfc_stop_n, 1'b0, "R8 clamp pfc");
        line_ovp = 0; cyc(2); chk(run_en, 1'b1, "R8 clamp resumes");
        // R10 brownout over idle
        stby_low = 1; line_low = 1; cyc(3); stby_low = 0;
        chk(ss_reset, 1'b1, "R10 brown beats idle"); chk(pfc_stop_n, 1'b1, "R10 pfc");
        line_low = 0; stby_wake = 1; cyc(3); stby_wake = 0;
        // R7 latch
        shdn = 1; cyc(1); shdn = 0; cyc(6);
        chk(run_en, 1'b0, "R7 latched"); chk(pfc_stop_n, 1'b0, "R7 latch pfc");
        vcc_on = 1; cyc(4); vcc_on = 0;
        chk(run_en, 1'b0, "R7 turn-on flag does not clear latch");
        vcc_hold = 0; cyc(3); vcc_hold = 1; vcc_on = 1; cyc(4); vcc_on = 0;
        chk(run_en, 1'b1, "R7 supply cycle clears");
        // R10 latch over line
        cs_latch = 1; line_low = 1; cyc(2); cs_latch = 0;
        chk(pfc_stop_n, 1'b0, "R10 latch beats brownout");
        line_low = 0; cyc(3); chk(run_en, 1'b0, "R7 current latch holds");
        vcc_hold = 0; cyc(3);
        chk(pfc_stop_n, 1'b1, "R1 uvlo pfc open");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule